// File: doc/BRIEF.md
# Four-Channel DMA Stop and Resume Controller

This block holds the control and status state of a small DMA engine with a parameterised number of channels (four by default). Each channel keeps a source address, a destination address, a remaining unit count and a control word. Each accepted request moves one unit through a valid/ready memory handshake. After each unit the addresses advance by the unit size and the count goes down by one. A shared operation word holds a master enable and two fault flags: an address-fault flag and a non-maskable-interrupt flag.

There are two ways for a channel to stop. A channel whose count runs out is complete: it raises its done flag and, if enabled, its interrupt. A channel that loses its enable, or that sees the master enable drop or either fault flag rise, is only suspended. It keeps its addresses, count and pending request, so it can go on later, and its done flag stays clear. Software reaches all state through a simple register port with a read latency of one cycle.

Top module: `dma_stop_ctrl`

## Requirements
- R1: When a unit completes on a channel whose count was 1, the count becomes 0, the channel's done flag (control bit 1) is set and the channel issues no further units.
- R2: `irq[n]` is high one cycle after the done flag and the interrupt-enable bit (control bit 2) are both 1. It stays high until software writes 0 to the done flag. Writing 1 to the done flag changes nothing.
- R3: Clearing a channel's enable bit (control bit 0) halts only that channel. Its done flag stays 0 and its count stays put. Its pending request is served once the bit is set again.
- R4: While the master enable (operation bit 0) is 0, no channel issues a unit. Pending requests are kept and are served once it returns to 1.
- R5: A pulse on `nmi` sets the NMI flag (operation bit 1) and halts every channel. The flag clears only under the same read-1-then-write-0 rule as R7.
- R6: A source or destination address that is not a multiple of the unit size sets the address-fault flag (operation bit 2) and issues nothing. The channel's addresses, count and done flag are left unchanged.
- R7: The address-fault flag clears only on a write of 0 to it after a read of the operation word that returned it as 1. A write of 0 with no such read leaves it set.
- R8: While the address-fault flag is set, every request is discarded and every pending request is lost. Once the flag is clear, a channel moves nothing until it gets a new request.
- R9: When several channels are ready at once, the lowest-numbered one is served first.
- R10: `mem_valid` and the address outputs hold steady until `mem_ready`. Unit size codes 0, 1, 2 and 3 move 1, 2, 4 and 4 bytes, and both addresses advance by that amount after each unit.
- R11: Register map: address 4n+0 is the source, 4n+1 the destination, 4n+2 the count and 4n+3 the control word of channel n. Control bits are [0] enable, [1] done, [2] interrupt enable and [4:3] size code. Address 4×NCH is the operation word. Everything resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADW | Register address |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Read data, valid the cycle after the read strobe |
| req | input | NCH | Per-channel transfer request pulses |
| nmi | input | 1 | Non-maskable interrupt pulse |
| mem_valid | output | 1 | A unit is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered unit |
| mem_src | output | AW | Source address of the unit |
| mem_dst | output | AW | Destination address of the unit |
| mem_size | output | 2 | Size code of the unit |
| mem_ch | output | CHW | Channel issuing the unit |
| irq | output | NCH | Per-channel completion interrupt |

## Verification
The hardest case to reach is the clearing of the address-fault flag. The flag must be raised by the design itself, then a write of 0 must be shown to fail, and only after that may a read arm the clear. The stimulus starts a channel at a misaligned source address and writes 0 to the operation word before any read of it. It then reads, writes 0 again, and shows that a request dropped while the flag was up never turns into a transfer. A stalled handshake, made by holding `mem_ready` low, shows that the offered unit stays stable.

// File: rtl/dma_stop_pkg.sv
package dma_stop_pkg;
  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    unit_bytes = 3'd1;
      2'd1:    unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic off_grid(input logic [1:0] lo, input logic [1:0] code);
    case (code)
      2'd0:    off_grid = 1'b0;
      2'd1:    off_grid = lo[0];
      default: off_grid = |lo;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_stop_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic          req,
  input  logic          drop,
  input  logic          run_ok,
  input  logic          done,
  output logic          runnable,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [1:0]    size,
  output logic          irq,
  output logic [AW-1:0] rd_data
);
  logic [CW-1:0] cnt;
  logic en, fin, ie, pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= '0; dst <= '0; cnt <= '0; size <= '0;
      en <= 1'b0; fin <= 1'b0; ie <= 1'b0; pend <= 1'b0; irq <= 1'b0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_SRC:  src <= wdata;
          SEL_DST:  dst <= wdata;
          SEL_CNT:  cnt <= wdata[CW-1:0];
          default: begin
            en   <= wdata[0];
            fin  <= fin & wdata[1];
            ie   <= wdata[2];
            size <= wdata[4:3];
          end
        endcase
      end
      if (done) begin
        src <= src + AW'(unit_bytes(size));
        dst <= dst + AW'(unit_bytes(size));
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) fin <= 1'b1;
      end
      if (drop)      pend <= 1'b0;
      else if (req)  pend <= 1'b1;
      else if (done) pend <= 1'b0;
      irq <= fin & ie;
    end
  end

  assign runnable = pend & en & ~fin & (cnt != '0) & run_ok;

  always_comb begin
    case (sel)
      SEL_SRC:  rd_data = src;
      SEL_DST:  rd_data = dst;
      SEL_CNT:  rd_data = AW'(cnt);
      default:  rd_data = AW'({size, ie, fin, en});
    endcase
  end

  assert_done_on_zero_R1: assert property (@(posedge clk) disable iff (rst)
    done && cnt == CW'(1) |=> fin);
  assert_fin_only_on_unit_R3: assert property (@(posedge clk) disable iff (rst)
    !done && !fin |=> !fin);
  assert_irq_held_R2: assert property (@(posedge clk) disable iff (rst)
    fin && ie && !(wr_en && sel == SEL_CTRL) |=> irq);
  assert_drop_clears_R8: assert property (@(posedge clk) disable iff (rst)
    drop |=> !pend);
endmodule

// File: rtl/dma_op_regs.sv
module dma_op_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] wdata,
  input  logic       nmi,
  input  logic       addr_err,
  output logic       master_en,
  output logic       nmi_flag,
  output logic       fault
);
  logic fault_arm, nmi_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0; nmi_flag <= 1'b0; fault <= 1'b0;
      fault_arm <= 1'b0; nmi_arm <= 1'b0;
    end else begin
      if (wr_en) master_en <= wdata[0];

      if (addr_err)                              fault <= 1'b1;
      else if (wr_en && !wdata[2] && fault_arm)  fault <= 1'b0;
      if (wr_en || addr_err)                     fault_arm <= 1'b0;
      else if (rd_en && fault)                   fault_arm <= 1'b1;

      if (nmi)                                   nmi_flag <= 1'b1;
      else if (wr_en && !wdata[1] && nmi_arm)    nmi_flag <= 1'b0;
      if (wr_en || nmi)                          nmi_arm <= 1'b0;
      else if (rd_en && nmi_flag)                nmi_arm <= 1'b1;
    end
  end

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    fault && !fault_arm |=> fault);
  assert_nmi_sets_R5: assert property (@(posedge clk) disable iff (rst)
    nmi |=> nmi_flag);
endmodule

// File: rtl/dma_unit_engine.sv
module dma_unit_engine
  import dma_stop_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NCH-1:0]           runnable,
  input  logic [NCH-1:0][AW-1:0]   src,
  input  logic [NCH-1:0][AW-1:0]   dst,
  input  logic [NCH-1:0][1:0]      size,
  input  logic                     mem_ready,
  output logic                     mem_valid,
  output logic [AW-1:0]            mem_src,
  output logic [AW-1:0]            mem_dst,
  output logic [1:0]               mem_size,
  output logic [CHW-1:0]           mem_ch,
  output logic [NCH-1:0]           done,
  output logic                     addr_err
);
  logic           found, bad;
  logic [CHW-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (runnable[i]) begin
        found = 1'b1;
        pick  = CHW'(i);
      end
    end
    bad = off_grid(src[pick][1:0], size[pick]) | off_grid(dst[pick][1:0], size[pick]);
  end

  assign addr_err = !mem_valid && found && bad;
  assign done     = (mem_valid && mem_ready) ? (NCH'(1) << mem_ch) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0; mem_src <= '0; mem_dst <= '0; mem_size <= '0; mem_ch <= '0;
    end else if (mem_valid) begin
      if (mem_ready) mem_valid <= 1'b0;
    end else if (found && !bad) begin
      mem_valid <= 1'b1;
      mem_src   <= src[pick];
      mem_dst   <= dst[pick];
      mem_size  <= size[pick];
      mem_ch    <= pick;
    end
  end

  assert_hold_offer_R10: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_src) && $stable(mem_dst) && $stable(mem_ch));
  assert_no_issue_on_fault_R6: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> !mem_valid);
  assert_single_done_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));
endmodule

// File: rtl/dma_stop_ctrl.sv
module dma_stop_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 16,
  localparam int ADW = $clog2(NCH * 4 + 1),
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [ADW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  input  logic [NCH-1:0] req,
  input  logic           nmi,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_src,
  output logic [AW-1:0]  mem_dst,
  output logic [1:0]     mem_size,
  output logic [CHW-1:0] mem_ch,
  output logic [NCH-1:0] irq
);
  localparam int IDXW = ADW - 2;
  localparam logic [ADW-1:0] OP_ADDR = ADW'(NCH * 4);

  logic                   is_op, master_en, nmi_flag, fault, addr_err;
  logic [IDXW-1:0]        idx;
  logic [NCH-1:0]         runnable, done;
  logic [NCH-1:0][AW-1:0] src_a, dst_a, rd_a;
  logic [NCH-1:0][1:0]    size_a;
  logic [AW-1:0]          rd_mux;

  assign is_op = (reg_addr == OP_ADDR);
  assign idx   = reg_addr[ADW-1:2];

  dma_op_regs u_op (
    .clk(clk), .rst(rst), .wr_en(reg_wr && is_op), .rd_en(reg_rd && is_op),
    .wdata(reg_wdata[2:0]), .nmi(nmi), .addr_err(addr_err),
    .master_en(master_en), .nmi_flag(nmi_flag), .fault(fault)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_regs #(.AW(AW), .CW(CW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_en(reg_wr && !is_op && idx == IDXW'(g)), .sel(reg_addr[1:0]), .wdata(reg_wdata),
      .req(req[g]), .drop(fault), .run_ok(master_en && !fault && !nmi_flag), .done(done[g]),
      .runnable(runnable[g]), .src(src_a[g]), .dst(dst_a[g]), .size(size_a[g]),
      .irq(irq[g]), .rd_data(rd_a[g])
    );
  end

  dma_unit_engine #(.NCH(NCH), .AW(AW)) u_eng (
    .clk(clk), .rst(rst), .runnable(runnable), .src(src_a), .dst(dst_a), .size(size_a),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_src(mem_src), .mem_dst(mem_dst),
    .mem_size(mem_size), .mem_ch(mem_ch), .done(done), .addr_err(addr_err)
  );

  always_comb begin
    rd_mux = '0;
    if (is_op) rd_mux = AW'({fault, nmi_flag, master_en});
    else
      for (int i = 0; i < NCH; i++)
        if (idx == IDXW'(i)) rd_mux = rd_a[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assert_halt_all_R4: assert property (@(posedge clk) disable iff (rst)
    (!master_en || nmi_flag || fault) |-> runnable == '0);
endmodule

// File: tb/dma_stop_ctrl_tb.sv
`timescale 1ns/1ps
module dma_stop_ctrl_tb;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int ADW = 5;
  localparam int OPA = 16;

  logic clk = 0, rst = 1, reg_wr = 0, reg_rd = 0, nmi = 0, mem_ready = 1;
  logic [ADW-1:0] reg_addr = '0;
  logic [AW-1:0]  reg_wdata = '0, reg_rdata, mem_src, mem_dst;
  logic [NCH-1:0] req = '0, irq;
  logic mem_valid;
  logic [1:0] mem_size, mem_ch;

  int checks = 0, fails = 0;
  logic [65:0] expq[$];

  always #2 clk = ~clk;

  dma_stop_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req), .nmi(nmi),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_src(mem_src), .mem_dst(mem_dst),
    .mem_size(mem_size), .mem_ch(mem_ch), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = ADW'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = ADW'(a);
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic expect_unit(input int c, input logic [31:0] s, input logic [31:0] d);
    expq.push_back({2'(c), s, d});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    chk(tag, 32'(expq.size()), 32'd0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: pop and compare each completed unit
  always @(negedge clk) begin
    #1;
    if (!rst && mem_valid && mem_ready) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4/R8 unexpected unit actual=ch%0d src=%h expected=none", mem_ch, mem_src);
      end else begin
        logic [65:0] e;
        e = expq.pop_front();
        chk("R9/R10 unit", {30'd0, mem_ch}, {30'd0, e[65:64]});
        chk("R10 unit src", mem_src, e[63:32]);
        chk("R10 unit dst", mem_dst, e[31:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    idle(3); rst = 0; idle(2);
    // R11 reset state
    rd_chk("R11 op reset", OPA, 0);
    rd_chk("R11 ctrl reset", 3, 0);
    chk("R11 irq reset", 32'(irq), 0);
    chk("R11 valid reset", 32'(mem_valid), 0);

    // R1 R2 R10: channel 0, word units, two units
    wr(0, 32'h100); wr(1, 32'h200); wr(2, 2); wr(3, 21); wr(OPA, 1);
    expect_unit(0, 32'h100, 32'h200); pulse(4'b0001); idle(6); drained("R10 first unit");
    expect_unit(0, 32'h104, 32'h204); pulse(4'b0001); idle(6); drained("R10 second unit");
    rd_chk("R1 done flag", 3, 23);
    rd_chk("R1 count zero", 2, 0);
    rd_chk("R10 src advanced", 0, 32'h108);
    chk("R2 irq raised", 32'(irq[0]), 1);
    pulse(4'b0001); idle(6);
    wr(3, 23); idle(2);
    chk("R2 write 1 keeps irq", 32'(irq[0]), 1);
    wr(3, 21); idle(2);
    chk("R2 irq cleared", 32'(irq[0]), 0);
    wr(3, 0);

    // R9 priority
    wr(4, 32'h301); wr(5, 32'h401); wr(6, 3); wr(7, 1);
    wr(8, 32'h600); wr(9, 32'h700); wr(10, 4); wr(11, 9);
    expect_unit(1, 32'h301, 32'h401); expect_unit(2, 32'h600, 32'h700);
    pulse(4'b0110); idle(8); drained("R9 both served");

    // R3 per-channel suspend
    wr(7, 0);
    expect_unit(2, 32'h602, 32'h702);
    pulse(4'b0110); idle(8); drained("R3 other channel runs");
    rd_chk("R3 done stays clear", 7, 0);
    rd_chk("R3 count held", 6, 2);
    expect_unit(1, 32'h302, 32'h402); wr(7, 1); idle(6); drained("R3 resumes pending");

    // R4 master enable
    wr(OPA, 0); pulse(4'b0100); idle(6);
    chk("R4 nothing offered", 32'(mem_valid), 0);
    rd_chk("R4 count held", 10, 2);
    expect_unit(2, 32'h604, 32'h704); wr(OPA, 1); idle(6); drained("R4 pending served");

    // R10 stalled handshake
    mem_ready = 0;
    expect_unit(2, 32'h606, 32'h706); pulse(4'b0100); idle(4);
    chk("R10 valid held", 32'(mem_valid), 1);
    chk("R10 src held", mem_src, 32'h606);
    idle(2);
    chk("R10 src still held", mem_src, 32'h606);
    mem_ready = 1; idle(4); drained("R10 stall done");
    rd_chk("R1 ch2 done", 11, 11);
    chk("R2 no irq without enable", 32'(irq[2]), 0);

    // R6 R7 R8 address fault
    wr(12, 32'h501); wr(13, 32'h800); wr(14, 2); wr(15, 17);
    pulse(4'b1000); idle(4);
    wr(OPA, 1);
    rd_chk("R7 plain write keeps fault", OPA, 5);
    rd_chk("R6 src kept", 12, 32'h501);
    rd_chk("R6 count kept", 14, 2);
    rd_chk("R6 done clear", 15, 17);
    pulse(4'b0010); idle(4);
    wr(OPA, 1);
    rd_chk("R7 fault cleared", OPA, 1);
    wr(15, 0); idle(6);
    rd_chk("R8 dropped request", 6, 1);
    expect_unit(1, 32'h303, 32'h403); pulse(4'b0010); idle(6); drained("R8 reissued request");

    // R5 NMI
    wr(10, 1); wr(11, 9);
    @(negedge clk); nmi = 1; @(negedge clk); nmi = 0;
    pulse(4'b0100); idle(6);
    chk("R5 halted", 32'(mem_valid), 0);
    wr(OPA, 1);
    rd_chk("R5 flag sticky", OPA, 3);
    expect_unit(2, 32'h608, 32'h708); wr(OPA, 1); idle(6); drained("R5 resumed");
    rd_chk("R5 flag cleared", OPA, 1);

    idle(4);
    report();
  end
endmodule